// File: doc/BRIEF.md
# Ordered-Compare ALU with Condition Flags and Branch Decision

This block is the execute stage of a small per-thread datapath. Each enabled clock it takes two unsigned 8-bit register operands and an operation code, and registers an 8-bit result. The available operations are wrapping add, wrapping subtract, low-byte multiply, integer divide, and an ordered compare. A compare writes a three-bit condition code into the low bits of the result word and also loads it into a condition register.

The condition code has three flags: negative, zero and positive. The flags come from a true unsigned ordering of the two operands, never from the sign of a wrapped difference. A combinational branch port takes the three-bit condition mask of a conditional-branch instruction and reports whether the stored flags satisfy it. Because the ordering is exact, swapping the compare operands and exchanging the n and p bits of the mask always gives the same branch decision.

Top module: `cba_exec_unit`

## Requirements
- R1: The result register loads the selected operation's value on a rising clock edge when `exe_en` is high, keeps its value when `exe_en` is low, and clears to 0 on an edge where the synchronous `rst` is high.
- R2: Op code 0 adds and op code 1 subtracts (a minus b), both modulo 256; for example a=1, b=2 with op 1 gives 255.
- R3: Op code 2 gives the low 8 bits of a times b. Op code 3 gives the integer quotient a divided by b, and 0 when b is 0.
- R4: Op code 4 (compare) gives a result with bits 7..3 zero, the n flag in bit 2, the z flag in bit 1 and the p flag in bit 0.
- R5: The compare flags follow unsigned magnitude order: n when a < b, z when a == b, p when a > b. Exactly one flag is set, so a=1, b=2 gives n=1, z=0, p=0.
- R6: The condition register, shown on `cond_flags` in the order n,z,p (bit 2 down to bit 0), loads the compare flags only on an enabled compare. Every other op, and any cycle with `exe_en` low, leaves it unchanged.
- R7: Synchronous reset clears the condition register to 000, so no mask gives a taken branch until the first compare.
- R8: `br_taken` is high exactly when `br_mask` (n at bit 2, z at bit 1, p at bit 0) shares at least one set bit with `cond_flags`. A mask of 000 is never taken.
- R9: A compare of (a,b) with mask {n,z,p} gives the same `br_taken` as a compare of (b,a) with mask {p,z,n}, for every mask and operand pair.
- R10: Op codes 5, 6 and 7 give a result of 0 and do not change the condition register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| exe_en | input | 1 | Execute enable; when high, the edge commits the operation |
| op_sel | input | 3 | Operation code: 0 add, 1 sub, 2 mul, 3 div, 4 compare |
| opnd_a | input | 8 | First unsigned operand |
| opnd_b | input | 8 | Second unsigned operand |
| alu_result | output | 8 | Registered operation result |
| cond_flags | output | 3 | Stored condition code, n at bit 2, z at bit 1, p at bit 0 |
| br_mask | input | 3 | Branch condition mask in the same n,z,p bit order |
| br_taken | output | 1 | Combinational branch decision against the stored flags |

## Verification
The assertions check on every cycle that the result and the condition register hold through idle cycles and non-compare ops, that the condition register never has more than one flag set and has exactly one after a compare, that a compare result has zero upper bits with its low bits equal to the stored flags, and that an empty mask never branches. Only the bench's scenarios can show that each flag sits on the correct side of the ordering. They also show that the arithmetic values are right, including wrap, low-byte product and divide by zero, and that swapping the operands with the mirrored mask gives the same decision. To cover these, the bench sweeps all 65,536 compare pairs against every mask and also runs explicit swap pairs.

// File: rtl/cba_pkg.sv
`timescale 1ns/1ps
package cba_pkg;

    localparam int unsigned FLAG_W = 3;
    localparam int unsigned FLG_N  = 2;
    localparam int unsigned FLG_Z  = 1;
    localparam int unsigned FLG_P  = 0;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MUL = 3'd2,
        OP_DIV = 3'd3,
        OP_CMP = 3'd4
    } alu_op_e;

endpackage

// File: rtl/cba_arith.sv
`timescale 1ns/1ps
module cba_arith
    import cba_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   res
);

    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] diff_w;
    logic [DATA_W-1:0] prod_w;
    logic [DATA_W-1:0] quot_w;
    logic              div_zero;

    always_comb begin
        sum_w    = a + b;
        diff_w   = a - b;
        prod_w   = a * b;
        div_zero = (b == '0);
        quot_w   = div_zero ? '0 : (a / b);
    end

    always_comb begin
        case (op)
            OP_ADD:  res = sum_w;
            OP_SUB:  res = diff_w;
            OP_MUL:  res = prod_w;
            OP_DIV:  res = quot_w;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/cba_compare.sv
`timescale 1ns/1ps
module cba_compare
    import cba_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [FLAG_W-1:0]   nzp,
    output logic [DATA_W-1:0]   word
);

    localparam int unsigned PAD_W = DATA_W - FLAG_W;

    logic lt_w;
    logic eq_w;
    logic gt_w;

    always_comb begin
        lt_w       = (a < b);
        eq_w       = (a == b);
        gt_w       = (a > b);
        nzp        = '0;
        nzp[FLG_N] = lt_w;
        nzp[FLG_Z] = eq_w;
        nzp[FLG_P] = gt_w;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {{PAD_W{1'b0}}, nzp};
        end else begin : g_nopad
            assign word = nzp[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/cba_branch.sv
`timescale 1ns/1ps
module cba_branch
    import cba_pkg::*;
(
    input  logic [FLAG_W-1:0] mask,
    input  logic [FLAG_W-1:0] flags,
    output logic              taken
);

    logic [FLAG_W-1:0] hit_w;

    always_comb begin
        hit_w = mask & flags;
        taken = |hit_w;
    end

endmodule

// File: rtl/cba_exec_unit.sv
`timescale 1ns/1ps
module cba_exec_unit
    import cba_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exe_en,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] alu_result,
    output logic [2:0]        cond_flags,
    input  logic [2:0]        br_mask,
    output logic              br_taken
);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic [FLAG_W-1:0] nzp;
    } exec_state_t;

    exec_state_t       st_d;
    exec_state_t       st_q;
    alu_op_e           op_w;
    logic [DATA_W-1:0] arith_res_w;
    logic [DATA_W-1:0] cmp_word_w;
    logic [FLAG_W-1:0] cmp_nzp_w;

    assign op_w = alu_op_e'(op_sel);

    cba_arith #(.DATA_W(DATA_W)) u_arith (
        .op  (op_w),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (arith_res_w)
    );

    cba_compare #(.DATA_W(DATA_W)) u_compare (
        .a    (opnd_a),
        .b    (opnd_b),
        .nzp  (cmp_nzp_w),
        .word (cmp_word_w)
    );

    cba_branch u_branch (
        .mask  (br_mask),
        .flags (st_q.nzp),
        .taken (br_taken)
    );

    always_comb begin
        st_d = st_q;
        if (exe_en) begin
            case (op_w)
                OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
                    st_d.result = arith_res_w;
                end
                OP_CMP: begin
                    st_d.result = cmp_word_w;
                    st_d.nzp    = cmp_nzp_w;
                end
                default: begin
                    st_d.result = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alu_result = st_q.result;
    assign cond_flags = st_q.nzp;

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !exe_en |=> $stable(alu_result)); // R1

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(exe_en && op_sel == 3'd4) |=> $stable(cond_flags)); // R6

    AST_FLAGS_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cond_flags)); // R5

    AST_CMP_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (exe_en && op_sel == 3'd4) |=> ($countones(cond_flags) == 1)); // R5

    AST_CMP_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (exe_en && op_sel == 3'd4) |=> (alu_result[DATA_W-1:FLAG_W] == '0)); // R4

    AST_CMP_LOW_MATCH: assert property (@(posedge clk) disable iff (rst)
        (exe_en && op_sel == 3'd4) |=> (alu_result[FLAG_W-1:0] == cond_flags)); // R4

    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
        (br_mask == 3'b000) |-> !br_taken); // R8

    AST_UNUSED_OP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (exe_en && op_sel > 3'd4) |=> (alu_result == '0)); // R10

endmodule

// File: tb/test_cba_exec_unit.sv
`timescale 1ns/1ps
module test_cba_exec_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       exe_en = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] opnd_a = 8'd0;
    logic [7:0] opnd_b = 8'd0;
    logic [7:0] alu_result;
    logic [2:0] cond_flags;
    logic [2:0] br_mask = 3'd0;
    logic       br_taken;

    int vectors = 0;
    int miscompares = 0;
    int m_res = 0;
    int m_nzp = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cba_exec_unit #(.DATA_W(8)) i_cba_exec_unit (
        .clk        (clk),
        .rst        (rst),
        .exe_en     (exe_en),
        .op_sel     (op_sel),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .alu_result (alu_result),
        .cond_flags (cond_flags),
        .br_mask    (br_mask),
        .br_taken   (br_taken)
    );

    task automatic check(input string req, input int actual, input int expected);
        vectors++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Behavioural model of one clock edge
    task automatic model_edge(input bit r, input bit en, input int op, input int a, input int b);
        if (r) begin
            m_res = 0;
            m_nzp = 0;
        end else if (en) begin
            case (op)
                0: m_res = (a + b) % 256;
                1: m_res = (a - b + 256) % 256;
                2: m_res = (a * b) % 256;
                3: m_res = (b == 0) ? 0 : a / b;
                4: begin
                    if (a < b)       m_nzp = 4;
                    else if (a == b) m_nzp = 2;
                    else             m_nzp = 1;
                    m_res = m_nzp;
                end
                default: m_res = 0;
            endcase
        end
    endtask

    task automatic step(input bit r, input bit en, input int op, input int a, input int b,
                        input string req);
        @(negedge clk);
        rst    = r;
        exe_en = en;
        op_sel = op[2:0];
        opnd_a = a[7:0];
        opnd_b = b[7:0];
        @(posedge clk);
        model_edge(r, en, op, a, b);
        #2;
        check({req, " result"}, int'(alu_result), m_res);
        check({req, " flags"}, int'(cond_flags), m_nzp);
    endtask

    task automatic taken_for(input int mask, output bit t);
        br_mask = mask[2:0];
        #0.1;
        t = br_taken;
    endtask

    // R8: every mask against the model flags
    task automatic check_all_masks(input string req);
        for (int mk = 0; mk < 8; mk++) begin
            bit t;
            taken_for(mk, t);
            check(req, int'(t), ((mk & m_nzp) != 0) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog all-reqs actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1 R7: synchronous reset overrides an enabled operation
        step(1, 1, 0, 5, 6, "R1 reset");
        step(1, 1, 4, 1, 2, "R7 reset");
        check_all_masks("R7 no branch after reset");
        step(0, 0, 0, 0, 0, "R1 idle after reset");
        check_all_masks("R7 no branch before compare");

        // R2
        step(0, 1, 0, 200, 100, "R2 add wrap");
        step(0, 1, 0, 17, 25, "R2 add");
        step(0, 1, 1, 1, 2, "R2 sub 1-2");
        step(0, 1, 1, 90, 30, "R2 sub");
        // R3
        step(0, 1, 2, 16, 17, "R3 mul low byte");
        step(0, 1, 2, 7, 9, "R3 mul");
        step(0, 1, 3, 200, 7, "R3 div");
        step(0, 1, 3, 99, 0, "R3 div by zero");
        step(0, 1, 3, 3, 9, "R3 div small");

        // R5: a=1, b=2 must give n only
        step(0, 1, 4, 1, 2, "R5 cmp 1,2");
        check(("R4 n bit2"), int'(alu_result), 4);
        // R6: non-compare ops and idle cycles leave flags
        step(0, 1, 0, 9, 1, "R6 add keeps flags");
        step(0, 1, 3, 9, 0, "R6 div keeps flags");
        step(0, 0, 4, 9, 1, "R6 disabled cmp ignored");
        step(0, 0, 2, 3, 3, "R1 disabled hold");
        check_all_masks("R8 after disabled cmp");
        // R10
        for (int op = 5; op < 8; op++) begin
            step(0, 1, op, 200, 1, "R10 unused op");
        end
        check_all_masks("R10 flags untouched");

        // R9: mirrored operands with n/p swapped in mask
        for (int pr = 0; pr < 6; pr++) begin
            int a;
            int b;
            a = (pr == 0) ? 1 : (pr == 1) ? 2 : (pr == 2) ? 2 : (pr == 3) ? 0 : (pr == 4) ? 255 : 128;
            b = (pr == 0) ? 2 : (pr == 1) ? 2 : (pr == 2) ? 1 : (pr == 3) ? 255 : (pr == 4) ? 0 : 127;
            for (int mk = 0; mk < 8; mk++) begin
                bit t1;
                bit t2;
                int mirr;
                mirr = ((mk & 4) >> 2) | (mk & 2) | ((mk & 1) << 2);
                step(0, 1, 4, a, b, "R9 cmp fwd");
                taken_for(mk, t1);
                step(0, 1, 4, b, a, "R9 cmp rev");
                taken_for(mirr, t2);
                check("R9 swap equivalence", int'(t2), int'(t1));
            end
        end

        // R4 R5 R8: exhaustive compare sweep, every mask
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                step(0, 1, 4, a, b, "R4 R5 sweep");
                check_all_masks("R8 sweep");
            end
        end

        // R1 R7: reset mid-run
        step(0, 1, 4, 3, 3, "R5 equal");
        step(1, 0, 0, 0, 0, "R7 mid reset");
        check_all_masks("R7 cleared flags");
        step(0, 1, 1, 0, 1, "R2 sub 0-1");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule